// File: doc/BRIEF.md
# Disk Adapter Command and Completion Interlock

This block holds the command logic of a virtual disk adapter. On one side is the host's I/O channel, which issues one-cycle command strobes that carry a 3-bit function code and a modifier bit. On the other side is a helper controller that does the real disk work, reached over a packet link. The block answers seek and sense commands by itself. It posts read and write initiations into a function field, and the helper collects that field with a poll strobe.

When the helper has finished an operation it pushes a status word. The block's only use of that word is to set an operation-complete flip-flop. That flip-flop drives the host's level-2 interrupt request. Only a host sense-with-reset clears it. The helper therefore never has to send a second push to withdraw completion. A completion level still held by the helper also cannot raise the interrupt again after the host has cleared it.

A command FSM tracks each disk operation through three states: idle, posted (waiting for the poll) and active (waiting for completion). Every path through the FSM leads back to idle.

Top module: `dsk_cmd_interlock`

## Requirements
- R1: After reset, `sense_word`, `poll_word`, `busy` and `irq_l2` are all zero.
- R2: When the block is idle, a command strobe with function 110 (read) or 101 (write) makes `poll_word` equal {1, function} and sets `busy` in the next cycle. In `poll_word`, bit 3 is the valid bit and bits 2:0 hold the function.
- R3: A `poll_stb` clears the valid bit (`poll_word[3]`) in the next cycle. The function bits are kept. After a poll, `busy` stays high, for any number of cycles, until completion is pushed.
- R4: A `push_stb` whose status word has bit 0 set sets operation complete. In the next cycle `irq_l2` is high and `busy` is low.
- R5: A pushed status word with bit 0 clear has no effect. `irq_l2` and `busy` keep their values, whatever the other bits hold.
- R6: A sense device command (function 111, modifier 0) loads `sense_word` in the next cycle. Bit 0 holds operation complete, bit 1 holds busy, and all other bits are zero. Operation complete is left unchanged.
- R7: A sense device with reset (function 111, modifier 1) loads `sense_word` with the status as it stood before the clear. It also clears operation complete, so `irq_l2` is low in the next cycle.
- R8: If a completion push and a sense-with-reset arrive in the same cycle, operation complete ends up set and `irq_l2` stays high.
- R9: A sense interrupt-level-status command (function 011) loads `sense_word` with the level-2 request in bit 0 and zeros elsewhere. It changes no other state.
- R10: A control (seek) command (function 100) changes none of `busy`, `poll_word`, `sense_word` or `irq_l2`.
- R11: A read or write command issued while `busy` is high is ignored. `poll_word` and `busy` are unchanged.
- R12: A completion push that arrives while an initiation is still waiting for its poll also returns the block to idle. It clears the valid bit, so the FSM has no dead end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_stb | input | 1 | Host command strobe, one cycle |
| cmd_func | input | 3 | Host function code |
| cmd_mod | input | 1 | Modifier; selects reset variant of sense device |
| poll_stb | input | 1 | Helper poll of the function field |
| push_stb | input | 1 | Helper status-word push strobe |
| push_word | input | SW_W | Pushed status word; bit DONE_BIT means complete |
| sense_word | output | SW_W | Status returned to the last sense command |
| poll_word | output | 4 | {valid, last function} seen by the helper |
| busy | output | 1 | A disk operation is posted or in progress |
| irq_l2 | output | 1 | Level-2 interrupt request |

## Verification
The hardest situation to reach is a completion push that arrives in the same cycle as the host's sense-with-reset. The bench drives both strobes together in a single task, with operation complete already set. It then checks that the request survives, and that a later lone reset does clear it. A second hard case is a push that overtakes the poll. The bench posts a write and pushes completion without polling, which checks that the posted state can exit on its own. Pushes with the complete bit clear, sent both during an operation and after completion, show that such a push is ignored.

// File: rtl/dsk_cmd_interlock.sv
module dsk_cmd_interlock #(
  parameter int SW_W     = 16,
  parameter int DONE_BIT = 0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_stb,
  input  logic [2:0]      cmd_func,
  input  logic            cmd_mod,
  input  logic            poll_stb,
  input  logic            push_stb,
  input  logic [SW_W-1:0] push_word,
  output logic [SW_W-1:0] sense_word,
  output logic [3:0]      poll_word,
  output logic            busy,
  output logic            irq_l2
);
  localparam logic [2:0] FN_CTRL  = 3'b100;
  localparam logic [2:0] FN_SENSE = 3'b111;
  localparam logic [2:0] FN_ILSW  = 3'b011;
  localparam logic [2:0] FN_WRITE = 3'b101;
  localparam logic [2:0] FN_READ  = 3'b110;

  typedef enum logic [1:0] {ST_IDLE, ST_POSTED, ST_ACTIVE} st_t;

  st_t             st;
  logic            done_q, fn_valid;
  logic [2:0]      fn_last;
  logic [SW_W-1:0] sense_q, sense_nx;
  logic            is_init, is_sense, is_ilsw, is_ctrl, done_set, done_clr;
  logic            unused_push_bits;

  assign is_init  = cmd_stb && (cmd_func == FN_READ || cmd_func == FN_WRITE);
  assign is_sense = cmd_stb && cmd_func == FN_SENSE;
  assign is_ilsw  = cmd_stb && cmd_func == FN_ILSW;
  assign is_ctrl  = cmd_stb && cmd_func == FN_CTRL;
  assign done_set = push_stb && push_word[DONE_BIT];
  assign done_clr = is_sense && cmd_mod;
  assign unused_push_bits = ^push_word;

  assign busy       = (st != ST_IDLE);
  assign irq_l2     = done_q;
  assign poll_word  = {fn_valid, fn_last};
  assign sense_word = sense_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      fn_valid <= 1'b0;
      fn_last  <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (poll_stb) fn_valid <= 1'b0;
          if (is_init) begin
            st       <= ST_POSTED;
            fn_last  <= cmd_func;
            fn_valid <= 1'b1;
          end
        end
        ST_POSTED: begin
          if (done_set) begin
            st       <= ST_IDLE;
            fn_valid <= 1'b0;
          end else if (poll_stb) begin
            st       <= ST_ACTIVE;
            fn_valid <= 1'b0;
          end
        end
        ST_ACTIVE: begin
          if (poll_stb) fn_valid <= 1'b0;
          if (done_set) st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        done_q <= 1'b0;
    else if (done_set) done_q <= 1'b1;
    else if (done_clr) done_q <= 1'b0;
  end

  always_comb begin
    sense_nx = '0;
    if (is_sense) begin
      sense_nx[0] = done_q;
      sense_nx[1] = busy;
    end else if (is_ilsw) begin
      sense_nx[0] = done_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                  sense_q <= '0;
    else if (is_sense || is_ilsw) sense_q <= sense_nx;
  end

  AST_PUSH_SETS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    done_set |=> irq_l2 && !busy); // R4
  AST_RESET_CLEARS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    done_clr && !push_stb |=> !irq_l2); // R7
  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    done_clr && done_set |=> irq_l2); // R8
  AST_POLL_DROPS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    poll_stb && busy |=> !poll_word[3]); // R3
  AST_ACTIVE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !done_set |=> busy); // R3
  AST_CLEAR_PUSH_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    push_stb && !push_word[DONE_BIT] && !cmd_stb |=> $stable(irq_l2) && $stable(busy)); // R5
  AST_CTRL_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    is_ctrl && !push_stb && !poll_stb |=>
      $stable(busy) && $stable(poll_word) && $stable(sense_word) && $stable(irq_l2)); // R10
  AST_INIT_IGNORED_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    is_init && busy && !push_stb && !poll_stb |=> $stable(poll_word)); // R11
endmodule

// File: tb/dsk_cmd_interlock_tb.sv
module dsk_cmd_interlock_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_stb = 1'b0, cmd_mod = 1'b0, poll_stb = 1'b0, push_stb = 1'b0;
  logic [2:0]  cmd_func = '0;
  logic [15:0] push_word = '0;
  logic [15:0] sense_word;
  logic [3:0]  poll_word;
  logic        busy, irq_l2;
  int          n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  dsk_cmd_interlock u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_stb(cmd_stb), .cmd_func(cmd_func), .cmd_mod(cmd_mod),
    .poll_stb(poll_stb), .push_stb(push_stb), .push_word(push_word),
    .sense_word(sense_word), .poll_word(poll_word), .busy(busy), .irq_l2(irq_l2));

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic cmd(input logic [2:0] f, input logic m);
    @(negedge clk); cmd_stb = 1'b1; cmd_func = f; cmd_mod = m;
    @(negedge clk); cmd_stb = 1'b0;
  endtask

  task automatic poll();
    @(negedge clk); poll_stb = 1'b1;
    @(negedge clk); poll_stb = 1'b0;
  endtask

  task automatic push(input logic [15:0] w);
    @(negedge clk); push_stb = 1'b1; push_word = w;
    @(negedge clk); push_stb = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 sense", sense_word, 16'h0);
    chk("R1 poll", {12'h0, poll_word}, 16'h0);
    chk("R1 busy", {15'h0, busy}, 16'h0);
    chk("R1 irq", {15'h0, irq_l2}, 16'h0);
  endtask

  task automatic t_control();
    cmd(3'b100, 1'b0);
    chk("R10 busy", {15'h0, busy}, 16'h0);
    chk("R10 poll", {12'h0, poll_word}, 16'h0);
    chk("R10 sense", sense_word, 16'h0);
    chk("R10 irq", {15'h0, irq_l2}, 16'h0);
  endtask

  task automatic t_read_cycle();
    cmd(3'b110, 1'b0);
    chk("R2 poll", {12'h0, poll_word}, 16'h000E);
    chk("R2 busy", {15'h0, busy}, 16'h1);
    cmd(3'b111, 1'b0);
    chk("R6 busy word", sense_word, 16'h0002);
    cmd(3'b101, 1'b0);
    chk("R11 poll", {12'h0, poll_word}, 16'h000E);
    chk("R11 busy", {15'h0, busy}, 16'h1);
    poll();
    chk("R3 valid", {12'h0, poll_word}, 16'h0006);
    chk("R3 busy", {15'h0, busy}, 16'h1);
    repeat (6) @(negedge clk);
    chk("R3 held", {15'h0, busy}, 16'h1);
    push(16'hFFFE);
    chk("R5 busy", {15'h0, busy}, 16'h1);
    chk("R5 irq", {15'h0, irq_l2}, 16'h0);
    push(16'h0001);
    chk("R4 irq", {15'h0, irq_l2}, 16'h1);
    chk("R4 busy", {15'h0, busy}, 16'h0);
    push(16'h0000);
    chk("R5 irq kept", {15'h0, irq_l2}, 16'h1);
    cmd(3'b011, 1'b0);
    chk("R9 ilsw", sense_word, 16'h0001);
    chk("R9 irq", {15'h0, irq_l2}, 16'h1);
    cmd(3'b111, 1'b0);
    chk("R6 done word", sense_word, 16'h0001);
    chk("R6 irq kept", {15'h0, irq_l2}, 16'h1);
    cmd(3'b111, 1'b1);
    chk("R7 prior word", sense_word, 16'h0001);
    chk("R7 irq", {15'h0, irq_l2}, 16'h0);
    cmd(3'b011, 1'b0);
    chk("R9 ilsw low", sense_word, 16'h0000);
  endtask

  task automatic t_posted_complete();
    cmd(3'b101, 1'b0);
    chk("R2 write", {12'h0, poll_word}, 16'h000D);
    push(16'h8001);
    chk("R12 busy", {15'h0, busy}, 16'h0);
    chk("R12 valid", {15'h0, poll_word[3]}, 16'h0);
    chk("R12 irq", {15'h0, irq_l2}, 16'h1);
    cmd(3'b111, 1'b1);
    chk("R7 irq", {15'h0, irq_l2}, 16'h0);
  endtask

  task automatic t_race();
    push(16'h0001);
    @(negedge clk);
    cmd_stb = 1'b1; cmd_func = 3'b111; cmd_mod = 1'b1;
    push_stb = 1'b1; push_word = 16'h0001;
    @(negedge clk);
    cmd_stb = 1'b0; push_stb = 1'b0;
    chk("R8 irq", {15'h0, irq_l2}, 16'h1);
    cmd(3'b111, 1'b1);
    chk("R7 after race", {15'h0, irq_l2}, 16'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_control();
    t_read_cycle();
    t_posted_complete();
    t_race();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule